// File: doc/BRIEF.md
# IDE Command-Window Timing Register Bank with Unlock Sequence

This block sits in the I/O decode path of a legacy IDE host controller, between the host access port and the drive-side command-block port. In normal operation every byte or halfword access at the command-block window goes straight through to the drive side. A fixed three-access key switches the window into a control mode. In control mode the same offsets reach an internal bank of timing registers, and nothing goes to the drive bus.

Control mode holds two staged timing banks, one for each attached device. Each bank has a read-cycle timing byte and a write-cycle timing byte. A select register picks the bank that receives writes and readback, and it also carries the address-setup value that both devices share. A strap register reports the bus-clock pin. A control register commits the staged values to the timing outputs. A relock key returns the window to normal IDE use.

The unlock logic is a four-state machine:
- `WS_IDE`: normal mode.
- `WS_RD1`: one key read seen.
- `WS_RD2`: two key reads seen.
- `WS_CTRL`: control mode.

Its transitions are:
- *first-read*: `WS_IDE` to `WS_RD1`.
- *second-read*: `WS_RD1` to `WS_RD2`.
- *unlock*: `WS_RD2` to `WS_CTRL`.
- *break*: `WS_RD1` or `WS_RD2` back to `WS_IDE`.
- *relock*: `WS_CTRL` to `WS_IDE`.

Cycles with no access leave the state unchanged.

Top module: `ide_cfg_window`

## Requirements
- R1: After reset the block is in normal mode (`ctl_mode` = 0). All committed read and write timings are 0xFF, the control register is 0, and the select register is 0xF0, so the committed setup output is 0xF.
- R2: The window enters control mode only after this exact order of accesses: a 16-bit read at offset 1, another 16-bit read at offset 1, then an 8-bit write of 0x03 at offset 2. `ctl_mode` is high from the clock edge that takes the write.
- R3: Any access that departs from the key sends the machine back to `WS_IDE` without entering control mode. This covers a wrong offset, a wrong width, a wrong value, or a third read at offset 1.
- R4: In normal mode every access is forwarded unchanged to the drive port, including the key accesses, and read data comes from `drv_rdata`.
- R5: In control mode `drv_valid` stays low. Read data comes from the internal registers, zero-extended to 16 bits.
- R6: In control mode an 8-bit write of 0x83 at offset 2 returns the window to normal mode. That write is not forwarded.
- R7: Bit 0 of the select register (offset 6) chooses the bank that takes writes at offset 0 (read timing) and offset 1 (write timing). Reads at offsets 0 and 1 return the chosen bank's staged byte.
- R8: Bits 7:4 of the select register hold the address-setup value that both devices share. It reaches `setup_tim` at the next commit.
- R9: Offset 5 reads the strap pin in bit 0, with the pin sampled by one register (0 = 33 MHz, 1 = 25 MHz). Writes to offset 5 have no effect.
- R10: A write of 0x85 to the control register (offset 3) copies bank 0 to device 0 and bank 1 to device 1 on the timing outputs. Any other control value is stored and read back, but it commits nothing. Staging writes alone never change the outputs.
- R11: In control mode a write at offset 2 of any value other than 0x83 has no effect, and the window stays in control mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| acc_offset | input | 3 | Offset within the command-block window |
| acc_wdata | input | 16 | Host write data |
| acc_rdata | output | 16 | Host read data, valid in the access cycle |
| drv_valid | output | 1 | Forwarded access strobe to the drive side |
| drv_write | output | 1 | Forwarded direction |
| drv_wide | output | 1 | Forwarded width |
| drv_offset | output | 3 | Forwarded offset |
| drv_wdata | output | 16 | Forwarded write data |
| drv_rdata | input | 16 | Read data returned by the drive side |
| strap_pin | input | 1 | Bus-clock strap, 1 = 25 MHz |
| ctl_mode | output | 1 | High while the window is in control mode |
| dev_rd_tim | output | 16 | Committed read timings, device d at bits [8d+7:8d] |
| dev_wr_tim | output | 16 | Committed write timings, device d at bits [8d+7:8d] |
| setup_tim | output | 4 | Committed shared address-setup value |

## Verification
Some properties are checked on every cycle. Control mode must never drive the drive-side strobe. A rise of `ctl_mode` must be preceded by the unlock write, and a fall by the relock write. The committed timings may change only on the cycle after a commit write. A strap read must match the sampled pin. Other behaviour needs the directed scenarios: the full key ordering and the ways to break it, bank selection with readback, a control value that commits nothing, a write to the read-only strap, and the exact values that land on the outputs.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;

    typedef enum logic [1:0] {
        WS_IDE  = 2'd0,
        WS_RD1  = 2'd1,
        WS_RD2  = 2'd2,
        WS_CTRL = 2'd3
    } win_state_t;

    // offsets decoded in control mode; the key offsets overlap task-file ones
    localparam int unsigned OFS_RD_TIM  = 0;
    localparam int unsigned OFS_WR_TIM  = 1;
    localparam int unsigned OFS_KEY     = 2;
    localparam int unsigned OFS_CTL     = 3;
    localparam int unsigned OFS_STRAP   = 5;
    localparam int unsigned OFS_SEL     = 6;

    localparam logic [7:0] KEY_UNLOCK = 8'h03;
    localparam logic [7:0] KEY_RELOCK = 8'h83;
    localparam logic [7:0] KEY_COMMIT = 8'h85;

endpackage

// File: rtl/ide_unlock_fsm.sv
module ide_unlock_fsm
    import ide_win_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic          acc_wide,
    input  logic [AW-1:0] acc_offset,
    input  logic [7:0]    acc_key,
    output logic          ctl_mode
);

    win_state_t state_q, state_d;

    logic is_key_rd;
    logic is_unlock;
    logic is_relock;

    assign is_key_rd = !acc_write && acc_wide && (acc_offset == AW'(OFS_WR_TIM));
    assign is_unlock = acc_write && !acc_wide && (acc_offset == AW'(OFS_KEY))
                       && (acc_key == KEY_UNLOCK);
    assign is_relock = acc_write && !acc_wide && (acc_offset == AW'(OFS_KEY))
                       && (acc_key == KEY_RELOCK);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_IDE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDE:  if (acc_valid && is_key_rd) state_d = WS_RD1;
            WS_RD1:  if (acc_valid) state_d = is_key_rd ? WS_RD2 : WS_IDE;
            WS_RD2:  if (acc_valid) state_d = is_unlock ? WS_CTRL : WS_IDE;
            WS_CTRL: if (acc_valid && is_relock) state_d = WS_IDE;
            default: state_d = WS_IDE;
        endcase
    end

    always_comb begin
        ctl_mode = 1'b0;
        unique case (state_q)
            WS_CTRL: ctl_mode = 1'b1;
            default: ctl_mode = 1'b0;
        endcase
    end

endmodule

// File: rtl/ide_timing_bank.sv
module ide_timing_bank
    import ide_win_pkg::*;
#(
    parameter int AW   = 3,
    parameter int TW   = 8,
    parameter int NDEV = 2,
    localparam int LO_W  = 4,
    localparam int SU_W  = TW - LO_W,
    localparam int SEL_W = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_offset,
    input  logic [TW-1:0]    reg_wdata,
    input  logic             strap_pin,
    output logic [TW-1:0]    reg_rdata,
    output logic [NDEV*TW-1:0] act_rd,
    output logic [NDEV*TW-1:0] act_wr,
    output logic [SU_W-1:0]  act_setup
);

    logic [TW-1:0]   sel_q;
    logic [TW-1:0]   ctl_q;
    logic            strap_q;
    logic [SU_W-1:0] setup_q;
    logic [TW-1:0]   stg_rd_v [NDEV];
    logic [TW-1:0]   stg_wr_v [NDEV];
    logic [SEL_W-1:0] sel_idx;
    logic            sel_ok;
    logic            commit;

    assign sel_idx = sel_q[SEL_W-1:0];
    assign sel_ok  = (32'(sel_idx) < NDEV);
    assign commit  = reg_wr && (reg_offset == AW'(OFS_CTL))
                     && (reg_wdata == TW'(KEY_COMMIT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= {{SU_W{1'b1}}, {LO_W{1'b0}}};
            ctl_q   <= '0;
            strap_q <= 1'b0;
            setup_q <= '1;
        end else begin
            strap_q <= strap_pin;
            if (reg_wr && reg_offset == AW'(OFS_SEL)) sel_q <= reg_wdata;
            if (reg_wr && reg_offset == AW'(OFS_CTL)) ctl_q <= reg_wdata;
            if (commit) setup_q <= sel_q[TW-1:LO_W];
        end
    end

    assign act_setup = setup_q;

    for (genvar d = 0; d < NDEV; d++) begin : g_bank
        logic [TW-1:0] s_rd, s_wr, a_rd, a_wr;
        logic          hit;

        assign hit = sel_ok && (32'(sel_idx) == d);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_rd <= '1;
                s_wr <= '1;
                a_rd <= '1;
                a_wr <= '1;
            end else begin
                if (reg_wr && hit && reg_offset == AW'(OFS_RD_TIM)) s_rd <= reg_wdata;
                if (reg_wr && hit && reg_offset == AW'(OFS_WR_TIM)) s_wr <= reg_wdata;
                if (commit) begin
                    a_rd <= s_rd;
                    a_wr <= s_wr;
                end
            end
        end

        assign stg_rd_v[d]          = s_rd;
        assign stg_wr_v[d]          = s_wr;
        assign act_rd[d*TW +: TW]   = a_rd;
        assign act_wr[d*TW +: TW]   = a_wr;
    end

    always_comb begin
        reg_rdata = '0;
        case (32'(reg_offset))
            OFS_RD_TIM: reg_rdata = sel_ok ? stg_rd_v[sel_idx] : '1;
            OFS_WR_TIM: reg_rdata = sel_ok ? stg_wr_v[sel_idx] : '1;
            OFS_CTL:    reg_rdata = ctl_q;
            OFS_STRAP:  reg_rdata = TW'(strap_q);
            OFS_SEL:    reg_rdata = sel_q;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ide_cfg_window.sv
module ide_cfg_window
    import ide_win_pkg::*;
#(
    parameter int AW   = 3,
    parameter int DW   = 16,
    parameter int TW   = 8,
    parameter int NDEV = 2,
    localparam int SU_W = TW - 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic               acc_wide,
    input  logic [AW-1:0]      acc_offset,
    input  logic [DW-1:0]      acc_wdata,
    output logic [DW-1:0]      acc_rdata,
    output logic               drv_valid,
    output logic               drv_write,
    output logic               drv_wide,
    output logic [AW-1:0]      drv_offset,
    output logic [DW-1:0]      drv_wdata,
    input  logic [DW-1:0]      drv_rdata,
    input  logic               strap_pin,
    output logic               ctl_mode,
    output logic [NDEV*TW-1:0] dev_rd_tim,
    output logic [NDEV*TW-1:0] dev_wr_tim,
    output logic [SU_W-1:0]    setup_tim
);

    logic [TW-1:0] reg_rdata;
    logic          reg_wr;

    ide_unlock_fsm #(.AW(AW)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_wide   (acc_wide),
        .acc_offset (acc_offset),
        .acc_key    (acc_wdata[7:0]),
        .ctl_mode   (ctl_mode)
    );

    assign reg_wr = ctl_mode && acc_valid && acc_write;

    ide_timing_bank #(.AW(AW), .TW(TW), .NDEV(NDEV)) bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_offset (acc_offset),
        .reg_wdata  (acc_wdata[TW-1:0]),
        .strap_pin  (strap_pin),
        .reg_rdata  (reg_rdata),
        .act_rd     (dev_rd_tim),
        .act_wr     (dev_wr_tim),
        .act_setup  (setup_tim)
    );

    assign drv_valid  = acc_valid && !ctl_mode;
    assign drv_write  = acc_write;
    assign drv_wide   = acc_wide;
    assign drv_offset = acc_offset;
    assign drv_wdata  = acc_wdata;
    assign acc_rdata  = ctl_mode ? DW'(reg_rdata) : drv_rdata;

endmodule

// File: rtl/ide_cfg_window_chk.sv
module ide_cfg_window_chk #(
    parameter int AW   = 3,
    parameter int DW   = 16,
    parameter int TW   = 8,
    parameter int NDEV = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic               acc_write,
    input logic               acc_wide,
    input logic [AW-1:0]      acc_offset,
    input logic [DW-1:0]      acc_wdata,
    input logic [DW-1:0]      acc_rdata,
    input logic               drv_valid,
    input logic               strap_pin,
    input logic               ctl_mode,
    input logic [NDEV*TW-1:0] dev_rd_tim,
    input logic [NDEV*TW-1:0] dev_wr_tim
);

    // R5
    ctl_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_mode |-> !drv_valid);

    // R2
    unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_mode) |-> $past(acc_valid && acc_write && !acc_wide
                                  && acc_offset == AW'(2) && acc_wdata[7:0] == 8'h03));

    // R6
    relock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_mode) |-> $past(ctl_mode && acc_valid && acc_write && !acc_wide
                                  && acc_offset == AW'(2) && acc_wdata[7:0] == 8'h83));

    // R10
    commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(dev_rd_tim) && $stable(dev_wr_tim))
        |-> $past(ctl_mode && acc_valid && acc_write
                  && acc_offset == AW'(3) && acc_wdata[7:0] == 8'h85));

    // R9
    strap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_mode && acc_valid && !acc_write && acc_offset == AW'(5))
        |-> acc_rdata[0] == $past(strap_pin));

endmodule

bind ide_cfg_window ide_cfg_window_chk #(.AW(AW), .DW(DW), .TW(TW), .NDEV(NDEV)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_wide   (acc_wide),
    .acc_offset (acc_offset),
    .acc_wdata  (acc_wdata),
    .acc_rdata  (acc_rdata),
    .drv_valid  (drv_valid),
    .strap_pin  (strap_pin),
    .ctl_mode   (ctl_mode),
    .dev_rd_tim (dev_rd_tim),
    .dev_wr_tim (dev_wr_tim)
);

// File: tb/ide_cfg_window_tb_top.sv
`timescale 1ns/1ps
module ide_cfg_window_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_wide = 1'b0;
    logic [2:0]  acc_offset = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        drv_valid, drv_write, drv_wide;
    logic [2:0]  drv_offset;
    logic [15:0] drv_wdata;
    logic [15:0] drv_rdata = 16'hA5C3;
    logic        strap_pin = 1'b0;
    logic        ctl_mode;
    logic [15:0] dev_rd_tim, dev_wr_tim;
    logic [3:0]  setup_tim;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] cap_rdata;
    logic        cap_dv, cap_dw, cap_dwide;
    logic [2:0]  cap_doff;
    logic [15:0] cap_dwdata;

    always #2.5 clk = ~clk;

    ide_cfg_window dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_wide(acc_wide),
        .acc_offset(acc_offset), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .drv_valid(drv_valid), .drv_write(drv_write), .drv_wide(drv_wide),
        .drv_offset(drv_offset), .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
        .strap_pin(strap_pin), .ctl_mode(ctl_mode),
        .dev_rd_tim(dev_rd_tim), .dev_wr_tim(dev_wr_tim), .setup_tim(setup_tim)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, tag, act, exp);
    endtask

    // one access: drive at negedge, capture combinational results, hold across posedge
    task automatic acc(input bit w, input bit wide, input logic [2:0] off,
                       input logic [15:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_wide = wide;
        acc_offset = off; acc_wdata = d;
        #1;
        cap_rdata = acc_rdata; cap_dv = drv_valid; cap_dw = drv_write;
        cap_dwide = drv_wide; cap_doff = drv_offset; cap_dwdata = drv_wdata;
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk_eq("R1 mode", ctl_mode, 0);
        chk_eq("R1 rd tim", dev_rd_tim, 16'hFFFF);
        chk_eq("R1 wr tim", dev_wr_tim, 16'hFFFF);
        chk_eq("R1 setup", setup_tim, 4'hF);
    endtask

    task automatic t_passthru();
        acc(1, 1, 3'd4, 16'h1234);
        chk_eq("R4 fwd valid", cap_dv, 1);
        chk_eq("R4 fwd fields", {cap_dw, cap_dwide, cap_doff, cap_dwdata},
               {1'b1, 1'b1, 3'd4, 16'h1234});
        acc(0, 0, 3'd7, 16'h0);
        chk_eq("R4 fwd rdata", cap_rdata, 16'hA5C3);
        chk_eq("R4 fwd read fields", {cap_dv, cap_dw, cap_dwide, cap_doff},
               {1'b1, 1'b0, 1'b0, 3'd7});
    endtask

    task automatic t_bad_seq();
        acc(0, 1, 3'd1, 0); acc(0, 0, 3'd1, 0); acc(1, 0, 3'd2, 16'h03);
        chk_eq("R3 narrow read breaks", ctl_mode, 0);
        acc(0, 1, 3'd1, 0); acc(0, 1, 3'd1, 0); acc(1, 0, 3'd2, 16'h04);
        chk_eq("R3 wrong value breaks", ctl_mode, 0);
        acc(0, 1, 3'd1, 0); acc(0, 1, 3'd1, 0); acc(0, 1, 3'd1, 0); acc(1, 0, 3'd2, 16'h03);
        chk_eq("R3 third read breaks", ctl_mode, 0);
        acc(0, 1, 3'd1, 0); acc(0, 1, 3'd3, 0); acc(1, 0, 3'd2, 16'h03);
        chk_eq("R3 wrong offset breaks", ctl_mode, 0);
        acc(0, 1, 3'd1, 0); acc(0, 1, 3'd1, 0); acc(1, 1, 3'd2, 16'h03);
        chk_eq("R3 wide write breaks", ctl_mode, 0);
    endtask

    task automatic t_unlock();
        acc(0, 1, 3'd1, 0);
        acc(0, 1, 3'd1, 0);
        chk_eq("R2 not yet", ctl_mode, 0);
        acc(1, 0, 3'd2, 16'h0003);
        chk_eq("R4 key write forwarded", cap_dv, 1);
        chk_eq("R2 unlocked", ctl_mode, 1);
    endtask

    task automatic t_isolate();
        acc(0, 0, 3'd0, 0);
        chk_eq("R5 no forward", cap_dv, 0);
        chk_eq("R5 reg readback", cap_rdata, 16'h00FF);
        acc(0, 0, 3'd6, 0);
        chk_eq("R1 select reset", cap_rdata, 16'h00F0);
        acc(0, 0, 3'd3, 0);
        chk_eq("R1 control reset", cap_rdata, 16'h0000);
    endtask

    task automatic t_banks();
        acc(1, 0, 3'd6, 16'h20);
        acc(1, 0, 3'd0, 16'h59); acc(1, 0, 3'd1, 16'h46);
        acc(1, 0, 3'd6, 16'h21);
        acc(1, 0, 3'd0, 16'h30); acc(1, 0, 3'd1, 16'h20);
        acc(0, 0, 3'd0, 0); chk_eq("R7 bank1 rd", cap_rdata, 16'h30);
        acc(0, 0, 3'd1, 0); chk_eq("R7 bank1 wr", cap_rdata, 16'h20);
        acc(1, 0, 3'd6, 16'h20);
        acc(0, 0, 3'd0, 0); chk_eq("R7 bank0 rd", cap_rdata, 16'h59);
        acc(0, 0, 3'd1, 0); chk_eq("R7 bank0 wr", cap_rdata, 16'h46);
        acc(1, 0, 3'd6, 16'h21);
        chk_eq("R10 staging leaves rd", dev_rd_tim, 16'hFFFF);
        chk_eq("R10 staging leaves setup", setup_tim, 4'hF);
    endtask

    task automatic t_commit();
        acc(1, 0, 3'd3, 16'h11);
        chk_eq("R10 non-key no commit", dev_rd_tim, 16'hFFFF);
        acc(0, 0, 3'd3, 0);
        chk_eq("R10 control stored", cap_rdata, 16'h11);
        acc(1, 0, 3'd3, 16'h85);
        chk_eq("R10 commit rd", dev_rd_tim, 16'h3059);
        chk_eq("R10 commit wr", dev_wr_tim, 16'h2046);
        chk_eq("R8 shared setup", setup_tim, 4'h2);
    endtask

    task automatic t_strap();
        @(negedge clk); strap_pin = 1'b1;
        acc(0, 0, 3'd5, 0);
        chk_eq("R9 strap one", cap_rdata, 16'h0001);
        acc(1, 0, 3'd5, 16'h00FE);
        acc(0, 0, 3'd5, 0);
        chk_eq("R9 write ignored", cap_rdata, 16'h0001);
        @(negedge clk); strap_pin = 1'b0;
        acc(0, 0, 3'd5, 0);
        chk_eq("R9 strap zero", cap_rdata, 16'h0000);
    endtask

    task automatic t_key_other();
        acc(1, 0, 3'd2, 16'h03);
        chk_eq("R11 stays control", ctl_mode, 1);
        chk_eq("R11 not forwarded", cap_dv, 0);
        acc(0, 0, 3'd0, 0);
        chk_eq("R11 regs intact", cap_rdata, 16'h30);
    endtask

    task automatic t_relock();
        acc(1, 0, 3'd2, 16'h83);
        chk_eq("R6 relock not forwarded", cap_dv, 0);
        chk_eq("R6 back to normal", ctl_mode, 0);
        acc(0, 0, 3'd0, 0);
        chk_eq("R6 window passes again", {cap_dv, cap_rdata}, {1'b1, 16'hA5C3});
        chk_eq("R10 outputs kept", dev_rd_tim, 16'h3059);
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthru();
        t_bad_seq();
        t_unlock();
        t_isolate();
        t_banks();
        t_commit();
        t_strap();
        t_key_other();
        t_relock();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule